// File: doc/BRIEF.md
# Instruction Cache with Critical-First Refill

This block is a read-only, four-way set-associative instruction cache placed between a processor fetch port and a memory refill port. A fetch that hits is granted in the cycle it is presented, and the addressed 64-bit double word appears on the response bus one cycle later. A fetch that misses starts a refill of the whole 32-byte line into a way chosen by an external replacement input. Memory returns the missed double word first and the remaining three in wrapping order. The critical double word is forwarded to the fetch port in the cycle it arrives.

Once the critical double word has arrived, the fetch port is open again. Hits to other lines are served while the line keeps streaming in. A fetch to the line being filled is granted in the cycle its double word arrives, or at once if that word is already stored. A miss to another line waits until the refill ends. Only one refill is in flight at a time. A single-cycle flash-invalidate input clears every valid bit. The array is written only by refills.

Top module: `icache_cf`

## Requirements
- R1: Fetch addresses are double-word aligned (bits [2:0] zero). A fetch granted at a clock edge (`fetch_gnt` high) gives `fetch_rvalid` high at the next edge, with the double word at that address on `fetch_rdata`. `fetch_rvalid` is low after every edge with no grant. A hit is granted in the cycle it is presented.
- R2: A miss raises `mem_req` with `mem_line_addr` equal to the aligned address of the missed double word (bits [31:5] give the line, bits [4:3] the critical double word). The request and its address hold until `mem_gnt` is seen.
- R3: The first beat after the grant is the critical double word. A fetch waiting on it is granted in the same cycle that beat is on `mem_rvalid`/`mem_rdata`, and it receives that data.
- R4: Beat k (k = 0..3) after the grant is stored as double word (critical + k) mod 4 of the line. Every double word then reads back correctly.
- R5: Between the start of a refill and the arrival of its critical beat, no fetch to another line is granted. This holds even if the missing fetch has been withdrawn. A withdrawn miss still completes its refill.
- R6: Once the critical beat has arrived, a fetch that hits another line is granted in the cycle it is presented, while the refill is still running.
- R7: A fetch to the line being filled whose double word has not arrived stalls. It is granted in the cycle that beat arrives. A double word that has already arrived is granted at once.
- R8: A miss to a different line during a refill is not granted and raises no new request until all four beats of the current refill have arrived. `mem_req` never rises while a refill is in progress.
- R9: After the fourth beat the line hits: later fetches to any of its double words are granted at once, with no new refill.
- R10: A refill replaces only the way given on `repl_way` (sampled when the miss is detected). A line is held in at most one way of its set. Lines in the other ways keep hitting.
- R11: A cycle with `flush_all` high clears every valid bit and grants no fetch. A later fetch to a previously cached line misses.
- R12: A flush during a refill does not stop the refill or its forwarding. The filled line is not left valid, so a later fetch to it misses again.
- R13: After reset, `mem_req`, `fetch_gnt` and `fetch_rvalid` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_req | input | 1 | Fetch request; may be withdrawn before it is granted |
| fetch_addr | input | 32 | Byte address of the fetch (double-word aligned) |
| fetch_gnt | output | 1 | Fetch accepted at this clock edge |
| fetch_rvalid | output | 1 | Response valid, one cycle after grant |
| fetch_rdata | output | 64 | Fetched double word |
| flush_all | input | 1 | Single-cycle flash invalidate of all lines |
| repl_way | input | 2 | Way to refill on the next miss |
| mem_req | output | 1 | Line refill request |
| mem_line_addr | output | 32 | Address of the critical double word of the requested line |
| mem_gnt | input | 1 | Memory accepts the refill request |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 64 | Refill beat data |

## Verification
The internal state can go wrong in a few ways, and each shows at the ports.
- A wrong fill pointer or wrap computation stores a beat in the wrong slot. The next read of that double word, from a hit or from same-line forwarding, returns data that does not match its own address.
- A valid bit set too early, too late or in the wrong way shows within a few cycles. A line that should hit raises a new `mem_req`, or a fetch is granted before its beat exists.
- A refill tracker that lets the fetch port open too soon, or too late, shows in the grant cycle itself. `fetch_gnt` rises before the critical beat, or stays low for a hit after it.
- A lost flush shows as a grant with no refill where a miss is expected.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [1:0] {
      FILL_IDLE = 2'd0,
      FILL_ASK  = 2'd1,
      FILL_RECV = 2'd2
   } fill_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
   parameter int SETS  = 128,
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [WAY_W-1:0] lk_way,
   input  logic             alloc_en,
   input  logic [IDX_W-1:0] alloc_idx,
   input  logic [WAY_W-1:0] alloc_way,
   input  logic [TAG_W-1:0] alloc_tag,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx,
   input  logic [WAY_W-1:0] mark_way,
   input  logic             flush
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_mem [SETS];
      logic [SETS-1:0]  vld;

      always_ff @(posedge clk) begin
         if (alloc_en && alloc_way == WAY_W'(w)) begin
            tag_mem[alloc_idx] <= alloc_tag;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld <= '0;
         end else if (flush) begin
            vld <= '0;
         end else begin
            if (alloc_en && alloc_way == WAY_W'(w)) begin
               vld[alloc_idx] <= 1'b0;
            end
            if (mark_en && mark_way == WAY_W'(w)) begin
               vld[mark_idx] <= 1'b1;
            end
         end
      end

      assign match[w] = vld[lk_idx] && (tag_mem[lk_idx] == lk_tag);
   end

   always_comb begin
      lk_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) begin
            lk_way = WAY_W'(w);
         end
      end
   end

   assign lk_hit = |match;

   // R10: a line never sits in two ways of one set
   p_single_way_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

endmodule

// File: rtl/icache_data.sv
module icache_data #(
   parameter int SETS   = 128,
   parameter int WAYS   = 4,
   parameter int BEATS  = 4,
   parameter int BEAT_W = 64,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int BI_W  = $clog2(BEATS),
   localparam int DEPTH = SETS * WAYS * BEATS,
   localparam int A_W   = IDX_W + WAY_W + BI_W
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WAY_W-1:0]  rd_way,
   input  logic [BI_W-1:0]   rd_beat,
   output logic [BEAT_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [BI_W-1:0]   wr_beat,
   input  logic [BEAT_W-1:0] wr_data
);

   logic [BEAT_W-1:0] mem [DEPTH];
   logic [A_W-1:0]    rd_a;
   logic [A_W-1:0]    wr_a;

   assign rd_a = {rd_idx, rd_way, rd_beat};
   assign wr_a = {wr_idx, wr_way, wr_beat};

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_a] <= wr_data;
      end
   end

   assign rd_data = mem[rd_a];

endmodule

// File: rtl/icache_refill.sv
module icache_refill
   import icache_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 7,
   parameter int TAG_W  = 20,
   parameter int WAY_W  = 2,
   parameter int BEATS  = 4,
   parameter int BOFF_W = 3,
   localparam int BI_W  = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TAG_W-1:0]  start_tag,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic [BI_W-1:0]   start_beat,
   input  logic [WAY_W-1:0]  start_way,
   input  logic              flush,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              busy,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [WAY_W-1:0]  fill_way,
   output logic [BI_W-1:0]   crit_beat,
   output logic [BEATS-1:0]  arrived,
   output logic              beat_now,
   output logic [BI_W-1:0]   beat_idx,
   output logic              line_done
);

   localparam logic [BI_W-1:0] LAST = BI_W'(BEATS - 1);

   fill_state_e     state;
   logic [BI_W-1:0] cnt;
   logic            poison;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FILL_IDLE;
         cnt       <= '0;
         arrived   <= '0;
         fill_tag  <= '0;
         fill_idx  <= '0;
         fill_way  <= '0;
         crit_beat <= '0;
      end else begin
         unique case (state)
            FILL_IDLE: begin
               if (start) begin
                  state     <= FILL_ASK;
                  fill_tag  <= start_tag;
                  fill_idx  <= start_idx;
                  fill_way  <= start_way;
                  crit_beat <= start_beat;
                  arrived   <= '0;
                  cnt       <= '0;
               end
            end
            FILL_ASK: begin
               if (mem_gnt) begin
                  state <= FILL_RECV;
               end
            end
            FILL_RECV: begin
               if (mem_rvalid) begin
                  arrived[beat_idx] <= 1'b1;
                  cnt               <= cnt + 1'b1;
                  if (cnt == LAST) begin
                     state <= FILL_IDLE;
                  end
               end
            end
            default: state <= FILL_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poison <= 1'b0;
      end else if (state == FILL_IDLE && start) begin
         poison <= 1'b0;
      end else if (state != FILL_IDLE && flush) begin
         poison <= 1'b1;
      end
   end

   assign busy      = (state != FILL_IDLE);
   assign mem_req   = (state == FILL_ASK);
   assign mem_addr  = {fill_tag, fill_idx, crit_beat, {BOFF_W{1'b0}}};
   assign beat_now  = (state == FILL_RECV) && mem_rvalid;
   assign beat_idx  = crit_beat + cnt;
   assign line_done = beat_now && (cnt == LAST) && !poison && !flush;

   // R2: request and its address hold until the grant
   p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   // R4: every beat lands in a slot not yet filled in this refill
   p_beat_free_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      beat_now |-> !arrived[beat_idx]);

endmodule

// File: rtl/icache_cf.sv
module icache_cf
   import icache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 128,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 32,
   parameter int BEAT_W     = 64,
   localparam int BEAT_BYTES = BEAT_W / 8,
   localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int BOFF_W     = $clog2(BEAT_BYTES),
   localparam int BI_W       = $clog2(BEATS),
   localparam int IDX_W      = $clog2(SETS),
   localparam int WAY_W      = $clog2(WAYS),
   localparam int TAG_W      = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_gnt,
   output logic              fetch_rvalid,
   output logic [BEAT_W-1:0] fetch_rdata,
   input  logic              flush_all,
   input  logic [WAY_W-1:0]  repl_way,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_line_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [BEAT_W-1:0] mem_rdata
);

   // elaboration-time parameter checks
   if (!is_pow2(SETS)) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (!is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (!is_pow2(BEAT_W) || BEAT_W < 8) begin : g_bad_beat
      $error("BEAT_W must be a power of two, at least 8");
   end
   if (!is_pow2(LINE_BYTES) || BEATS < 2) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least two beats");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   // fetch address fields
   logic [TAG_W-1:0] f_tag;
   logic [IDX_W-1:0] f_idx;
   logic [BI_W-1:0]  f_beat;

   assign f_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
   assign f_idx  = fetch_addr[OFF_W +: IDX_W];
   assign f_beat = fetch_addr[BOFF_W +: BI_W];

   // internal nets
   logic              lk_hit;
   logic [WAY_W-1:0]  lk_way;
   logic              busy;
   logic [TAG_W-1:0]  fill_tag;
   logic [IDX_W-1:0]  fill_idx;
   logic [WAY_W-1:0]  fill_way;
   logic [BI_W-1:0]   crit_beat;
   logic [BEATS-1:0]  arrived;
   logic              beat_now;
   logic [BI_W-1:0]   beat_idx;
   logic              line_done;
   logic              same_line;
   logic              crit_done;
   logic              fwd_now;
   logic              fwd_old;
   logic              accept;
   logic              start_miss;
   logic [WAY_W-1:0]  rd_way;
   logic [BEAT_W-1:0] arr_data;
   logic [BEAT_W-1:0] rsp_d;

   icache_tags #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (f_idx),
      .lk_tag    (f_tag),
      .lk_hit    (lk_hit),
      .lk_way    (lk_way),
      .alloc_en  (start_miss),
      .alloc_idx (f_idx),
      .alloc_way (repl_way),
      .alloc_tag (f_tag),
      .mark_en   (line_done),
      .mark_idx  (fill_idx),
      .mark_way  (fill_way),
      .flush     (flush_all)
   );

   icache_refill #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .WAY_W  (WAY_W),
      .BEATS  (BEATS),
      .BOFF_W (BOFF_W)
   ) u_refill (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_miss),
      .start_tag  (f_tag),
      .start_idx  (f_idx),
      .start_beat (f_beat),
      .start_way  (repl_way),
      .flush      (flush_all),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_req    (mem_req),
      .mem_addr   (mem_line_addr),
      .busy       (busy),
      .fill_tag   (fill_tag),
      .fill_idx   (fill_idx),
      .fill_way   (fill_way),
      .crit_beat  (crit_beat),
      .arrived    (arrived),
      .beat_now   (beat_now),
      .beat_idx   (beat_idx),
      .line_done  (line_done)
   );

   icache_data #(
      .SETS   (SETS),
      .WAYS   (WAYS),
      .BEATS  (BEATS),
      .BEAT_W (BEAT_W)
   ) u_data (
      .clk     (clk),
      .rd_idx  (f_idx),
      .rd_way  (rd_way),
      .rd_beat (f_beat),
      .rd_data (arr_data),
      .wr_en   (beat_now),
      .wr_idx  (fill_idx),
      .wr_way  (fill_way),
      .wr_beat (beat_idx),
      .wr_data (mem_rdata)
   );

   // fetch arbitration against the refill in flight
   assign same_line = busy && (f_tag == fill_tag) && (f_idx == fill_idx);
   assign crit_done = arrived[crit_beat];
   assign fwd_now   = same_line && beat_now && (beat_idx == f_beat);
   assign fwd_old   = same_line && arrived[f_beat];

   always_comb begin
      accept = 1'b0;
      if (fetch_req && !flush_all) begin
         if (!busy) begin
            accept = lk_hit;
         end else if (same_line) begin
            accept = fwd_now || fwd_old;
         end else begin
            accept = crit_done && lk_hit;
         end
      end
   end

   assign start_miss = fetch_req && !flush_all && !busy && !lk_hit;
   assign rd_way     = same_line ? fill_way : lk_way;
   assign rsp_d      = fwd_now ? mem_rdata : arr_data;
   assign fetch_gnt  = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_rvalid <= 1'b0;
         fetch_rdata  <= '0;
      end else begin
         fetch_rvalid <= accept;
         if (accept) begin
            fetch_rdata <= rsp_d;
         end
      end
   end

   // R1: fetch addresses are double-word aligned
   p_aligned_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> (fetch_addr[BOFF_W-1:0] == '0));

   // R1: a response follows each grant and only a grant
   p_rsp_after_gnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_gnt |=> fetch_rvalid);
   p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_gnt |=> !fetch_rvalid);

   // R5: nothing outside the filling line passes before the critical beat
   p_gate_before_crit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_gnt && busy && !same_line) |-> arrived[crit_beat]);

   // R8: a new refill request only ever starts from an idle tracker
   p_single_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(!busy));

   // R11: a flush cycle grants nothing
   p_flush_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !fetch_rvalid);

endmodule

// File: tb/icache_cf_test.sv
`timescale 1ns/1ps
module icache_cf_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_gnt;
   logic        fetch_rvalid;
   logic [63:0] fetch_rdata;
   logic        flush_all = 1'b0;
   logic [1:0]  repl_way = 2'd0;
   logic        mem_req;
   logic [31:0] mem_line_addr;
   logic        mem_gnt = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;

   always #10 clk = ~clk;

   icache_cf uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .fetch_req     (fetch_req),
      .fetch_addr    (fetch_addr),
      .fetch_gnt     (fetch_gnt),
      .fetch_rvalid  (fetch_rvalid),
      .fetch_rdata   (fetch_rdata),
      .flush_all     (flush_all),
      .repl_way      (repl_way),
      .mem_req       (mem_req),
      .mem_line_addr (mem_line_addr),
      .mem_gnt       (mem_gnt),
      .mem_rvalid    (mem_rvalid),
      .mem_rdata     (mem_rdata)
   );

   int          checks = 0;
   int          fails = 0;
   int          gnt_delay = 1;
   int          beat_gap = 0;
   int          req_count = 0;
   int          beats_cur = 0;
   bit          refill_open = 1'b0;
   int          overlap_err = 0;
   logic [31:0] last_req_addr = '0;

   localparam logic [31:0] A = 32'h0001_0040;
   localparam logic [31:0] B = 32'h0002_0040;
   localparam logic [31:0] C = 32'h0003_0040;
   localparam logic [31:0] D = 32'h0004_0080;
   localparam logic [31:0] E = 32'h0005_00C0;
   localparam logic [31:0] F = 32'h0006_0100;
   localparam logic [31:0] G = 32'h0007_0140;
   localparam logic [31:0] H = 32'h0008_0180;
   localparam logic [31:0] I = 32'h0009_01C0;

   function automatic logic [63:0] dw_data(input logic [31:0] a);
      logic [31:0] b;
      b = {a[31:3], 3'b000};
      return {~b, b};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic print_summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   // memory side: counts handshakes and flags overlapping requests
   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req && refill_open) overlap_err++;
         if (mem_req && mem_gnt) begin
            req_count++;
            last_req_addr = mem_line_addr;
            refill_open = 1'b1;
            beats_cur = 0;
         end
         if (mem_rvalid) begin
            beats_cur++;
            if (beats_cur == 4) refill_open = 1'b0;
         end
      end
   end

   // memory model: grant after gnt_delay, then four wrapping beats
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_req) begin
            logic [31:0] a;
            a = mem_line_addr;
            repeat (gnt_delay - 1) @(negedge clk);
            mem_gnt = 1'b1;
            @(negedge clk);
            mem_gnt = 1'b0;
            for (int i = 0; i < 4; i++) begin
               logic [1:0] bi;
               bi = a[4:3] + 2'(i);
               repeat (beat_gap) @(negedge clk);
               mem_rvalid = 1'b1;
               mem_rdata  = dw_data({a[31:5], bi, 3'b000});
               @(negedge clk);
               mem_rvalid = 1'b0;
            end
         end
      end
   end

   task automatic fetch(input logic [31:0] a, output logic [63:0] d,
                        output bit rv, output int w, output bit at_beat);
      @(negedge clk);
      fetch_req  = 1'b1;
      fetch_addr = a;
      w = 0;
      #5;
      while (!fetch_gnt && w < 400) begin
         @(negedge clk);
         #5;
         w++;
      end
      at_beat = mem_rvalid;
      @(negedge clk);
      fetch_req = 1'b0;
      rv = fetch_rvalid;
      d  = fetch_rdata;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (refill_open || mem_req) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      #5;
      check(mem_req == 1'b0, "R13", "mem_req after reset", 64'(mem_req), 0);
      check(fetch_gnt == 1'b0, "R13", "fetch_gnt after reset", 64'(fetch_gnt), 0);
      check(fetch_rvalid == 1'b0, "R13", "fetch_rvalid after reset", 64'(fetch_rvalid), 0);
   endtask

   task automatic t_first_miss();
      logic [63:0] d; bit rv; int w; bit ab;
      gnt_delay = 2; beat_gap = 0; repl_way = 2'd0;
      fetch(A + 32'h10, d, rv, w, ab);
      check(w > 0, "R13", "first fetch after reset misses", 64'(w), 1);
      check(req_count == 1, "R2", "one refill request", 64'(req_count), 1);
      check(last_req_addr == A + 32'h10, "R2", "critical address", 64'(last_req_addr), 64'(A + 32'h10));
      check(ab, "R3", "granted with critical beat", 64'(ab), 1);
      check(rv && d == dw_data(A + 32'h10), "R3", "critical data", d, dw_data(A + 32'h10));
      wait_idle();
   endtask

   task automatic t_wrap();
      logic [63:0] d; bit rv; int w; bit ab;
      for (int k = 0; k < 4; k++) begin
         fetch(A + 32'(k * 8), d, rv, w, ab);
         check(w == 0, "R9", "filled line hits", 64'(w), 0);
         check(rv && d == dw_data(A + 32'(k * 8)), "R4", "wrapped beat placement", d, dw_data(A + 32'(k * 8)));
      end
      check(req_count == 1, "R9", "no refill on hits", 64'(req_count), 1);
      check(rv, "R1", "response one cycle after grant", 64'(rv), 1);
   endtask

   task automatic t_replace();
      logic [63:0] d; bit rv; int w; bit ab; int rc;
      repl_way = 2'd1;
      fetch(B, d, rv, w, ab); wait_idle();
      repl_way = 2'd0;
      fetch(C, d, rv, w, ab); wait_idle();
      rc = req_count;
      fetch(B + 32'h8, d, rv, w, ab);
      check(w == 0 && req_count == rc, "R10", "other way kept", 64'(w), 0);
      check(d == dw_data(B + 32'h8), "R10", "other way data", d, dw_data(B + 32'h8));
      fetch(A, d, rv, w, ab);
      check(w > 0 && req_count == rc + 1, "R10", "victim way evicted", 64'(req_count), 64'(rc + 1));
      check(d == dw_data(A), "R10", "refetched data", d, dw_data(A));
      wait_idle();
   endtask

   task automatic t_hit_during_fill();
      logic [63:0] d; bit rv; int w; bit ab;
      beat_gap = 6;
      fetch(D, d, rv, w, ab);
      fetch(A + 32'h8, d, rv, w, ab);
      check(w == 0, "R6", "hit granted during refill", 64'(w), 0);
      check(refill_open, "R6", "refill still running", 64'(refill_open), 1);
      check(d == dw_data(A + 32'h8), "R6", "hit data during refill", d, dw_data(A + 32'h8));
      wait_idle();
   endtask

   task automatic t_same_line();
      logic [63:0] d; bit rv; int w; bit ab;
      beat_gap = 4;
      fetch(E + 32'h18, d, rv, w, ab);
      check(d == dw_data(E + 32'h18), "R3", "critical dw3 data", d, dw_data(E + 32'h18));
      fetch(E + 32'h08, d, rv, w, ab);
      check(w > 0, "R7", "pending beat stalls", 64'(w), 1);
      check(ab, "R7", "granted as beat arrives", 64'(ab), 1);
      check(d == dw_data(E + 32'h08), "R7", "forwarded data", d, dw_data(E + 32'h08));
      fetch(E + 32'h18, d, rv, w, ab);
      check(w == 0 && d == dw_data(E + 32'h18), "R7", "arrived beat at once", 64'(w), 0);
      wait_idle();
   endtask

   task automatic t_block_before_crit();
      logic [63:0] d; bit rv; int w; bit ab;
      gnt_delay = 6; beat_gap = 0;
      @(negedge clk); fetch_req = 1'b1; fetch_addr = F;
      @(negedge clk); fetch_req = 1'b0;
      fetch(A, d, rv, w, ab);
      check(w >= 5, "R5", "hit held until critical beat", 64'(w), 5);
      check(d == dw_data(A), "R5", "held hit data", d, dw_data(A));
      wait_idle();
      gnt_delay = 1;
      fetch(F + 32'h18, d, rv, w, ab);
      check(w == 0 && d == dw_data(F + 32'h18), "R5", "withdrawn miss still filled", 64'(w), 0);
   endtask

   task automatic t_miss_during_fill();
      logic [63:0] d; bit rv; int w; bit ab; int rc;
      beat_gap = 5;
      rc = req_count;
      fetch(G, d, rv, w, ab);
      fetch(H + 32'h8, d, rv, w, ab);
      check(w >= 15, "R8", "second miss waits for refill", 64'(w), 15);
      check(overlap_err == 0, "R8", "no overlapping request", 64'(overlap_err), 0);
      check(req_count == rc + 2 && last_req_addr == H + 32'h8, "R8", "second request address",
            64'(last_req_addr), 64'(H + 32'h8));
      check(d == dw_data(H + 32'h8), "R8", "second miss data", d, dw_data(H + 32'h8));
      wait_idle();
   endtask

   task automatic t_flush();
      logic [63:0] d; bit rv; int w; bit ab; int rc;
      beat_gap = 0;
      @(negedge clk); flush_all = 1'b1; fetch_req = 1'b1; fetch_addr = A;
      #5;
      check(fetch_gnt == 1'b0, "R11", "no grant in flush cycle", 64'(fetch_gnt), 0);
      @(negedge clk); flush_all = 1'b0; fetch_req = 1'b0;
      rc = req_count;
      fetch(A, d, rv, w, ab);
      check(w > 0 && req_count == rc + 1, "R11", "flushed line misses", 64'(req_count), 64'(rc + 1));
      check(d == dw_data(A), "R11", "data after flush", d, dw_data(A));
      wait_idle();
      fetch(B, d, rv, w, ab);
      check(req_count == rc + 2, "R11", "other way flushed too", 64'(req_count), 64'(rc + 2));
      wait_idle();
   endtask

   task automatic t_flush_in_fill();
      logic [63:0] d; bit rv; int w; bit ab; int rc;
      beat_gap = 3;
      fetch(I, d, rv, w, ab);
      @(negedge clk); flush_all = 1'b1;
      @(negedge clk); flush_all = 1'b0;
      fetch(I + 32'h10, d, rv, w, ab);
      check(rv && d == dw_data(I + 32'h10), "R12", "forward after flush in refill", d, dw_data(I + 32'h10));
      wait_idle();
      rc = req_count;
      fetch(I, d, rv, w, ab);
      check(req_count == rc + 1, "R12", "line left invalid", 64'(req_count), 64'(rc + 1));
      wait_idle();
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      print_summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_first_miss();
      t_wrap();
      t_replace();
      t_hit_during_fill();
      t_same_line();
      t_block_before_crit();
      t_miss_during_fill();
      t_flush();
      t_flush_in_fill();
      print_summary();
      $finish;
   end

endmodule